// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block sits on the downstream path of a PCI-to-PCI bridge. For each address it is given, it decides whether the bridge claims the access and forwards it to the secondary side. The bridge has three programmable windows: one for I/O space, one for non-prefetchable memory and one for prefetchable memory. It also has the fixed legacy VGA ranges. The block takes the packed base and limit register fields as they sit in configuration space. It rebuilds the full bounds from them, applies the granularity fill-in on each limit and adds the optional wide upper halves. It then compares the address against every active window.

Each clock edge captures a request (address, space type, valid) together with the register fields and enables. Combinational logic then decodes the captured values, so the result appears on the outputs one cycle after the request was presented. The outputs are a forward hit and a one-hot indicator of the window that claimed the access. When ranges overlap, a fixed priority picks the window.

Top module: `brw_top`

## Requirements
- R1: A request presented with `reqValid` high is captured on a rising clock edge, and `hitValid` is high during the following cycle. While `hitValid` is low, `fwdHit` and `hitWin` are zero. Reset clears all three outputs.
- R2: The I/O window base is built as follows. Bits 7:4 of `ioBaseReg` become address bits 15:12, and bits 11:0 are zero. When bits 3:0 of `ioBaseReg` equal 1 (32-bit I/O), `ioBaseHi` supplies address bits 31:16. For any other type value those bits are zero.
- R3: The I/O window limit is built from `ioLimReg` and `ioLimHi`, using the limit register's own type nibble in the same way as R2. Bits 11:0 are then all ones, which gives 4 KB granularity.
- R4: The non-prefetchable memory base places `memBaseAddr` (register bits 15:4) at address bits 31:20, with bits 19:0 zero. Its limit places `memLimAddr` at the same bits and sets bits 19:0 to ones. Address bits 63:32 are zero for both.
- R5: The prefetchable window follows the R4 layout, taking bits 15:4 of `prefBaseReg` and `prefLimReg`. When a register's bits 3:0 equal 1 (64-bit), the matching 32-bit upper register (`prefBaseHi` or `prefLimHi`) supplies address bits 63:32. Otherwise those bits are zero.
- R6: The I/O window can claim only requests with `reqIsIo` = 1, and only while `ioSpaceEn` is set. The two memory windows can claim only requests with `reqIsIo` = 0, and only while `memSpaceEn` is set.
- R7: A window whose limit is numerically below its base claims no address.
- R8: While `vgaFwdEn` is set, the legacy ranges are forwarded no matter how the space enables are set. These are I/O 0x3B0–0x3BB and 0x3C0–0x3DF, and memory 0xA0000–0xBFFFF. While it is clear, none of these ranges is claimed through VGA.
- R9: `hitWin` is one-hot or zero. Bit 0 is I/O, bit 1 is non-prefetchable memory, bit 2 is prefetchable memory and bit 3 is VGA. When ranges overlap, VGA wins over non-prefetchable memory, which wins over prefetchable memory. `fwdHit` is the OR of the four bits.
- R10: A window claims an address when base ≤ address ≤ limit. Both ends are inclusive, and the addresses one below the base and one above the limit miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqIsIo | input | 1 | 1 = I/O space, 0 = memory space |
| reqAddr | input | 64 | Request address |
| ioSpaceEn | input | 1 | I/O space enable from the command register |
| memSpaceEn | input | 1 | Memory space enable from the command register |
| vgaFwdEn | input | 1 | VGA enable from bridge control |
| ioBaseReg | input | 8 | I/O base register (address nibble 7:4, type 3:0) |
| ioLimReg | input | 8 | I/O limit register (address nibble 7:4, type 3:0) |
| ioBaseHi | input | 16 | I/O base upper 16 bits |
| ioLimHi | input | 16 | I/O limit upper 16 bits |
| memBaseAddr | input | 12 | Memory base register bits 15:4 |
| memLimAddr | input | 12 | Memory limit register bits 15:4 |
| prefBaseReg | input | 16 | Prefetchable base register (address 15:4, type 3:0) |
| prefLimReg | input | 16 | Prefetchable limit register (address 15:4, type 3:0) |
| prefBaseHi | input | 32 | Prefetchable base upper 32 bits |
| prefLimHi | input | 32 | Prefetchable limit upper 32 bits |
| hitValid | output | 1 | Decode result valid |
| fwdHit | output | 1 | Access is forwarded downstream |
| hitWin | output | 4 | One-hot claiming window |

## Verification
The assertions take for granted that `reqValid` is held low while reset is asserted. Without that, the captured valid would not follow the input one cycle later. They also assume that the register fields and enables change only together with a request, since they are sampled on the same edge. The bench drives every input at the falling edge and changes the configuration only during an idle cycle. It keeps the type nibbles at 0 or 1, and it spaces requests so that each result is compared in the cycle after its capture.

// File: rtl/brw_pkg.sv
package brw_pkg;
  localparam int ADDR_W    = 64;
  localparam int IO_W      = 32;
  localparam int TYPE_W    = 4;
  localparam int IO_NIB_W  = 4;
  localparam int IO_HI_W   = 16;
  localparam int MEM_FLD_W = 12;
  localparam int PREF_HI_W = 32;
  localparam int IO_GRAN   = 12;
  localparam int MEM_GRAN  = 20;
  localparam int NWIN      = 3;
  localparam int SEL_W     = NWIN + 1;

  localparam int WIN_IO   = 0;
  localparam int WIN_MEM  = 1;
  localparam int WIN_PREF = 2;
  localparam int WIN_VGA  = 3;

  localparam logic [TYPE_W-1:0] TYPE_WIDE = 4'h1;

  typedef logic [ADDR_W-1:0] addrT;

  localparam addrT VGA_IO_A_LO = 64'h3B0;
  localparam addrT VGA_IO_A_HI = 64'h3BB;
  localparam addrT VGA_IO_B_LO = 64'h3C0;
  localparam addrT VGA_IO_B_HI = 64'h3DF;
  localparam addrT VGA_MEM_LO  = 64'hA0000;
  localparam addrT VGA_MEM_HI  = 64'hBFFFF;

  // strobes from the control decode to the window datapath
  typedef struct packed {
    logic ioWinOn;
    logic memWinOn;
    logic vgaIoOn;
    logic vgaMemOn;
    logic ioBase32;
    logic ioLim32;
    logic prefBase64;
    logic prefLim64;
  } strobeT;
endpackage

// File: rtl/brw_ctrl.sv
module brw_ctrl
  import brw_pkg::*;
(
  input  logic              reqValid,
  input  logic              reqIsIo,
  input  logic              ioSpaceEn,
  input  logic              memSpaceEn,
  input  logic              vgaFwdEn,
  input  logic [TYPE_W-1:0] ioBaseType,
  input  logic [TYPE_W-1:0] ioLimType,
  input  logic [TYPE_W-1:0] prefBaseType,
  input  logic [TYPE_W-1:0] prefLimType,
  output strobeT            strb
);
  always_comb begin
    strb.ioWinOn    = reqValid && reqIsIo && ioSpaceEn;
    strb.memWinOn   = reqValid && !reqIsIo && memSpaceEn;
    strb.vgaIoOn    = reqValid && reqIsIo && vgaFwdEn;
    strb.vgaMemOn   = reqValid && !reqIsIo && vgaFwdEn;
    strb.ioBase32   = (ioBaseType == TYPE_WIDE);
    strb.ioLim32    = (ioLimType == TYPE_WIDE);
    strb.prefBase64 = (prefBaseType == TYPE_WIDE);
    strb.prefLim64  = (prefLimType == TYPE_WIDE);
  end
endmodule

// File: rtl/brw_datapath.sv
module brw_datapath
  import brw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobeT               strb,
  input  addrT                 reqAddr,
  input  logic [IO_NIB_W-1:0]  ioBaseNib,
  input  logic [IO_NIB_W-1:0]  ioLimNib,
  input  logic [IO_HI_W-1:0]   ioBaseHi,
  input  logic [IO_HI_W-1:0]   ioLimHi,
  input  logic [MEM_FLD_W-1:0] memBaseAddr,
  input  logic [MEM_FLD_W-1:0] memLimAddr,
  input  logic [MEM_FLD_W-1:0] prefBaseAddr,
  input  logic [MEM_FLD_W-1:0] prefLimAddr,
  input  logic [PREF_HI_W-1:0] prefBaseHi,
  input  logic [PREF_HI_W-1:0] prefLimHi,
  output logic                 fwdHit,
  output logic [SEL_W-1:0]     hitWin
);
  localparam int IO_PAD  = ADDR_W - IO_W;
  localparam int MEM_PAD = ADDR_W - MEM_FLD_W - MEM_GRAN;

  addrT winLo [NWIN];
  addrT winHi [NWIN];
  logic [NWIN-1:0] winOn;
  logic [NWIN-1:0] inWin;
  logic vgaHit;

  always_comb begin
    winLo[WIN_IO] = {{IO_PAD{1'b0}}, (strb.ioBase32 ? ioBaseHi : {IO_HI_W{1'b0}}),
                     ioBaseNib, {IO_GRAN{1'b0}}};
    winHi[WIN_IO] = {{IO_PAD{1'b0}}, (strb.ioLim32 ? ioLimHi : {IO_HI_W{1'b0}}),
                     ioLimNib, {IO_GRAN{1'b1}}};
    winLo[WIN_MEM] = {{MEM_PAD{1'b0}}, memBaseAddr, {MEM_GRAN{1'b0}}};
    winHi[WIN_MEM] = {{MEM_PAD{1'b0}}, memLimAddr, {MEM_GRAN{1'b1}}};
    winLo[WIN_PREF] = {(strb.prefBase64 ? prefBaseHi : {PREF_HI_W{1'b0}}),
                       prefBaseAddr, {MEM_GRAN{1'b0}}};
    winHi[WIN_PREF] = {(strb.prefLim64 ? prefLimHi : {PREF_HI_W{1'b0}}),
                       prefLimAddr, {MEM_GRAN{1'b1}}};
    winOn[WIN_IO]   = strb.ioWinOn;
    winOn[WIN_MEM]  = strb.memWinOn;
    winOn[WIN_PREF] = strb.memWinOn;
  end

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    assign inWin[g] = winOn[g] && (winHi[g] >= winLo[g]) &&
                      (reqAddr >= winLo[g]) && (reqAddr <= winHi[g]);
  end

  always_comb begin
    vgaHit = 1'b0;
    if (strb.vgaIoOn)
      vgaHit = ((reqAddr >= VGA_IO_A_LO) && (reqAddr <= VGA_IO_A_HI)) ||
               ((reqAddr >= VGA_IO_B_LO) && (reqAddr <= VGA_IO_B_HI));
    else if (strb.vgaMemOn)
      vgaHit = (reqAddr >= VGA_MEM_LO) && (reqAddr <= VGA_MEM_HI);
  end

  always_comb begin
    hitWin = '0;
    if (vgaHit)               hitWin[WIN_VGA]  = 1'b1;
    else if (inWin[WIN_MEM])  hitWin[WIN_MEM]  = 1'b1;
    else if (inWin[WIN_PREF]) hitWin[WIN_PREF] = 1'b1;
    else if (inWin[WIN_IO])   hitWin[WIN_IO]   = 1'b1;
  end

  assign fwdHit = |hitWin;

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitWin)); // R9
  AST_IO_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    hitWin[WIN_IO] |-> strb.ioWinOn); // R6
  AST_MEM_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (hitWin[WIN_MEM] || hitWin[WIN_PREF]) |-> strb.memWinOn); // R6
  AST_VGA_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    hitWin[WIN_VGA] |-> (strb.vgaIoOn || strb.vgaMemOn)); // R8
endmodule

// File: rtl/brw_top.sv
module brw_top
  import brw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqIsIo,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic                 ioSpaceEn,
  input  logic                 memSpaceEn,
  input  logic                 vgaFwdEn,
  input  logic [7:0]           ioBaseReg,
  input  logic [7:0]           ioLimReg,
  input  logic [IO_HI_W-1:0]   ioBaseHi,
  input  logic [IO_HI_W-1:0]   ioLimHi,
  input  logic [MEM_FLD_W-1:0] memBaseAddr,
  input  logic [MEM_FLD_W-1:0] memLimAddr,
  input  logic [15:0]          prefBaseReg,
  input  logic [15:0]          prefLimReg,
  input  logic [PREF_HI_W-1:0] prefBaseHi,
  input  logic [PREF_HI_W-1:0] prefLimHi,
  output logic                 hitValid,
  output logic                 fwdHit,
  output logic [SEL_W-1:0]     hitWin
);
  logic                 vQ, ioQ, ioEnQ, memEnQ, vgaEnQ;
  addrT                 addrQ;
  logic [7:0]           ioBaseQ, ioLimQ;
  logic [IO_HI_W-1:0]   ioBaseHiQ, ioLimHiQ;
  logic [MEM_FLD_W-1:0] memBaseQ, memLimQ;
  logic [15:0]          prefBaseQ, prefLimQ;
  logic [PREF_HI_W-1:0] prefBaseHiQ, prefLimHiQ;
  strobeT               strb;
  logic                 dpHit;
  logic [SEL_W-1:0]     dpWin;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vQ <= 1'b0; ioQ <= 1'b0; addrQ <= '0;
      ioEnQ <= 1'b0; memEnQ <= 1'b0; vgaEnQ <= 1'b0;
      ioBaseQ <= '0; ioLimQ <= '0; ioBaseHiQ <= '0; ioLimHiQ <= '0;
      memBaseQ <= '0; memLimQ <= '0; prefBaseQ <= '0; prefLimQ <= '0;
      prefBaseHiQ <= '0; prefLimHiQ <= '0;
    end else begin
      vQ <= reqValid; ioQ <= reqIsIo; addrQ <= reqAddr;
      ioEnQ <= ioSpaceEn; memEnQ <= memSpaceEn; vgaEnQ <= vgaFwdEn;
      ioBaseQ <= ioBaseReg; ioLimQ <= ioLimReg;
      ioBaseHiQ <= ioBaseHi; ioLimHiQ <= ioLimHi;
      memBaseQ <= memBaseAddr; memLimQ <= memLimAddr;
      prefBaseQ <= prefBaseReg; prefLimQ <= prefLimReg;
      prefBaseHiQ <= prefBaseHi; prefLimHiQ <= prefLimHi;
    end
  end

  brw_ctrl u_ctrl (
    .reqValid     (vQ),
    .reqIsIo      (ioQ),
    .ioSpaceEn    (ioEnQ),
    .memSpaceEn   (memEnQ),
    .vgaFwdEn     (vgaEnQ),
    .ioBaseType   (ioBaseQ[3:0]),
    .ioLimType    (ioLimQ[3:0]),
    .prefBaseType (prefBaseQ[3:0]),
    .prefLimType  (prefLimQ[3:0]),
    .strb         (strb)
  );

  brw_datapath u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .reqAddr      (addrQ),
    .ioBaseNib    (ioBaseQ[7:4]),
    .ioLimNib     (ioLimQ[7:4]),
    .ioBaseHi     (ioBaseHiQ),
    .ioLimHi      (ioLimHiQ),
    .memBaseAddr  (memBaseQ),
    .memLimAddr   (memLimQ),
    .prefBaseAddr (prefBaseQ[15:4]),
    .prefLimAddr  (prefLimQ[15:4]),
    .prefBaseHi   (prefBaseHiQ),
    .prefLimHi    (prefLimHiQ),
    .fwdHit       (dpHit),
    .hitWin       (dpWin)
  );

  assign hitValid = vQ;
  assign fwdHit   = dpHit;
  assign hitWin   = dpWin;

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> hitValid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !hitValid |-> (!fwdHit && hitWin == '0)); // R1
endmodule

// File: tb/sim_brw_top.sv
module sim_brw_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqIsIo = 1'b0;
  logic [63:0] reqAddr = '0;
  logic        ioSpaceEn = 1'b0, memSpaceEn = 1'b0, vgaFwdEn = 1'b0;
  logic [7:0]  ioBaseReg = '0, ioLimReg = '0;
  logic [15:0] ioBaseHi = '0, ioLimHi = '0;
  logic [11:0] memBaseAddr = '0, memLimAddr = '0;
  logic [15:0] prefBaseReg = '0, prefLimReg = '0;
  logic [31:0] prefBaseHi = '0, prefLimHi = '0;
  logic        hitValid, fwdHit;
  logic [3:0]  hitWin;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  logic [4:0] expQ[$];
  string      tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  brw_top u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsIo(reqIsIo), .reqAddr(reqAddr),
    .ioSpaceEn(ioSpaceEn), .memSpaceEn(memSpaceEn), .vgaFwdEn(vgaFwdEn),
    .ioBaseReg(ioBaseReg), .ioLimReg(ioLimReg), .ioBaseHi(ioBaseHi), .ioLimHi(ioLimHi),
    .memBaseAddr(memBaseAddr), .memLimAddr(memLimAddr),
    .prefBaseReg(prefBaseReg), .prefLimReg(prefLimReg),
    .prefBaseHi(prefBaseHi), .prefLimHi(prefLimHi),
    .hitValid(hitValid), .fwdHit(fwdHit), .hitWin(hitWin)
  );

  // expected {fwdHit, hitWin} from the requirements
  function automatic logic [4:0] model(input logic isIo, input logic [63:0] a);
    logic [63:0] ioL, ioH, mL, mH, pL, pH;
    logic vga, inIo, inMem, inPref;
    ioL = {32'h0, (ioBaseReg[3:0] == 4'd1) ? ioBaseHi : 16'h0, ioBaseReg[7:4], 12'h000};
    ioH = {32'h0, (ioLimReg[3:0] == 4'd1) ? ioLimHi : 16'h0, ioLimReg[7:4], 12'hFFF};
    mL  = {32'h0, memBaseAddr, 20'h00000};
    mH  = {32'h0, memLimAddr, 20'hFFFFF};
    pL  = {(prefBaseReg[3:0] == 4'd1) ? prefBaseHi : 32'h0, prefBaseReg[15:4], 20'h00000};
    pH  = {(prefLimReg[3:0] == 4'd1) ? prefLimHi : 32'h0, prefLimReg[15:4], 20'hFFFFF};
    if (isIo) vga = vgaFwdEn && ((a >= 64'h3B0 && a <= 64'h3BB) || (a >= 64'h3C0 && a <= 64'h3DF));
    else      vga = vgaFwdEn && (a >= 64'hA0000 && a <= 64'hBFFFF);
    inIo   = isIo && ioSpaceEn && a >= ioL && a <= ioH;
    inMem  = !isIo && memSpaceEn && a >= mL && a <= mH;
    inPref = !isIo && memSpaceEn && a >= pL && a <= pH;
    if (vga)         return 5'b1_1000;
    else if (inMem)  return 5'b1_0010;
    else if (inPref) return 5'b1_0100;
    else if (inIo)   return 5'b1_0001;
    return 5'b0_0000;
  endfunction

  task automatic send(input logic isIo, input logic [63:0] a, input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqIsIo = isIo; reqAddr = a;
    expQ.push_back(model(isIo, a));
    tagQ.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expectFixed(input logic [4:0] act, input logic [4:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // monitor: every valid result is checked against the queue head
  always @(negedge clk) begin
    if (rstN && !done && hitValid) begin
      if (expQ.size() == 0) begin
        vectors++; miscompares++;
        $display("FAIL R1 unexpected result actual=%b expected=none", {fwdHit, hitWin});
      end else begin
        logic [4:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        expectFixed({fwdHit, hitWin}, e, t);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expectFixed({fwdHit, hitWin}, 5'b0, "R1 reset outputs");
    vectors++;
    if (hitValid !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 reset hitValid actual=%b expected=0", hitValid);
    end
    @(negedge clk); rstN = 1'b1;

    // I/O 16-bit window 0x2000..0x3FFF
    idle();
    ioSpaceEn = 1'b1; ioBaseReg = 8'h20; ioLimReg = 8'h30; ioBaseHi = 16'h7; ioLimHi = 16'h7;
    send(1'b1, 64'h1FFF, "R10 io below base");
    send(1'b1, 64'h2000, "R2 io at base");
    send(1'b1, 64'h3FFF, "R3 io at limit");
    send(1'b1, 64'h4000, "R10 io above limit");
    send(1'b1, 64'h7_2000, "R2 io hi ignored in 16-bit");
    send(1'b0, 64'h2000, "R6 mem request at io window");
    idle();
    // idle output check
    @(negedge clk);
    expectFixed({hitValid, fwdHit, hitWin[2:0]}, 5'b0, "R1 idle quiet");

    // I/O 32-bit window 0x12000..0x12FFF
    ioBaseReg = 8'h21; ioLimReg = 8'h21; ioBaseHi = 16'h1; ioLimHi = 16'h1;
    send(1'b1, 64'h12000, "R2 io32 base");
    send(1'b1, 64'h12FFF, "R3 io32 limit");
    send(1'b1, 64'h13000, "R3 io32 above");
    send(1'b1, 64'h2000, "R2 io32 low alias miss");
    idle();
    ioSpaceEn = 1'b0;
    send(1'b1, 64'h12000, "R6 io disabled");
    idle();

    // memory window 0x12300000..0x124FFFFF
    memSpaceEn = 1'b1; memBaseAddr = 12'h123; memLimAddr = 12'h124;
    send(1'b0, 64'h122F_FFFF, "R10 mem below");
    send(1'b0, 64'h1230_0000, "R4 mem base");
    send(1'b0, 64'h124F_FFFF, "R4 mem limit");
    send(1'b0, 64'h1250_0000, "R10 mem above");
    send(1'b0, 64'h1_1230_0000, "R4 mem above 4G");
    send(1'b1, 64'h1230_0000, "R6 io request at mem window");
    idle();

    // prefetchable 0x80000000..0x800FFFFF, upper ignored with type 0
    prefBaseReg = 16'h8000; prefLimReg = 16'h8000; prefBaseHi = 32'h5; prefLimHi = 32'h5;
    send(1'b0, 64'h8000_0000, "R5 pref32 hit");
    send(1'b0, 64'h5_8000_0000, "R5 pref32 upper ignored");
    idle();
    prefBaseReg = 16'h8001; prefLimReg = 16'h8001;
    send(1'b0, 64'h5_8000_0000, "R5 pref64 base");
    send(1'b0, 64'h5_800F_FFFF, "R5 pref64 limit");
    send(1'b0, 64'h8000_0000, "R5 pref64 low miss");
    idle();
    memSpaceEn = 1'b0;
    send(1'b0, 64'h5_8000_0000, "R6 mem disabled pref");
    idle();

    // inverted window
    memSpaceEn = 1'b1; memBaseAddr = 12'h200; memLimAddr = 12'h100;
    send(1'b0, 64'h1000_0000, "R7 inverted at limit");
    send(1'b0, 64'h2000_0000, "R7 inverted at base");
    send(1'b0, 64'h1800_0000, "R7 inverted middle");
    idle();

    // VGA with space enables off
    memSpaceEn = 1'b0; ioSpaceEn = 1'b0; vgaFwdEn = 1'b1;
    send(1'b1, 64'h3B0, "R8 vga io a low");
    send(1'b1, 64'h3BB, "R8 vga io a high");
    send(1'b1, 64'h3BC, "R8 vga io gap");
    send(1'b1, 64'h3DF, "R8 vga io b high");
    send(1'b1, 64'h3E0, "R8 vga io above");
    send(1'b0, 64'hA0000, "R8 vga mem low");
    send(1'b0, 64'hBFFFF, "R8 vga mem high");
    send(1'b0, 64'hC0000, "R8 vga mem above");
    send(1'b0, 64'h9FFFF, "R8 vga mem below");
    send(1'b1, 64'hA0000, "R8 io at vga mem range");
    idle();
    vgaFwdEn = 1'b0;
    send(1'b1, 64'h3C0, "R8 vga disabled");
    idle();

    // priority: mem and pref both cover 0..0xFFFFF, vga on
    vgaFwdEn = 1'b1; memSpaceEn = 1'b1; memBaseAddr = 12'h000; memLimAddr = 12'h000;
    prefBaseReg = 16'h0000; prefLimReg = 16'h0000;
    send(1'b0, 64'hA0000, "R9 vga over mem");
    send(1'b0, 64'h50000, "R9 mem over pref");
    idle();
    memBaseAddr = 12'h001; memLimAddr = 12'h000;
    send(1'b0, 64'h50000, "R9 pref alone");
    idle();

    repeat (3) @(negedge clk);
    vectors++;
    if (expQ.size() != 0) begin
      miscompares++;
      $display("FAIL R1 results missing actual=%0d pending expected=0", expQ.size());
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule